// File: doc/BRIEF.md
# Serial Flash Status Register and Write-Protect Unit

This block owns the eight-bit status register of a serial NOR flash and decides whether each state-changing request from the command decoder may proceed. The decoder presents one request per cycle as an operation code. Program and erase requests also carry an inclusive start and end byte address. The block answers one cycle later with a grant or a deny. It tracks the write-enable latch and the busy flag, and applies the protection selected by the four block-protect bits and the status-lock bit together with the active-low write-protect pin.

A granted modifying operation raises the busy flag for a fixed number of clock cycles. This stands in for the real program, erase or register-write time. When the busy time ends, both the busy flag and the write-enable latch drop. The protected region for a 512-kB array comes from a four-bit code. Some codes protect a top-aligned region of one eighth, one quarter or one half of the array. Other codes protect the whole array from address 0 except for a small top slice of 4, 8, 16, 32, 128 or 256 kB.

Top module: `sflash_prot_top`

## Requirements
- R1: After a synchronous reset the status byte is 00h, busy is low and no response is issued.
- R2: Status layout is bit0 busy (WIP), bit1 write-enable latch, bits 5..2 protect code (bit2 is the code LSB), bit6 reserved and bit7 status lock. Bit6 always reads 0. A status write loads only bits 7 and 5..2 from the data byte.
- R3: Operation codes are 0 status read, 1 write enable, 2 write disable, 3 status write, 4 program, 5 erase, 6 chip erase and 7 unsupported. Codes 1 and 2 are always granted and set or clear the latch. Code 0 is always granted and changes nothing.
- R4: A modifying request (codes 3 to 6) is denied while the write-enable latch is clear.
- R5: A status write is denied when the status lock bit is 1 and the write-protect pin is low. The register is left unchanged.
- R6: Protect codes 0000 and 1000 protect nothing. 0001 protects 70000h-7FFFFh, 0010 protects 60000h-7FFFFh and 0011 protects 40000h-7FFFFh. 0100 through 0111 protect the whole array.
- R7: Codes 1001, 1010, 1011, 1100, 1101 and 1110 protect from 0 up to 7EFFFh, 7DFFFh, 7BFFFh, 77FFFh, 5FFFFh and 3FFFFh respectively. 1111 protects the whole array.
- R8: A program or erase is denied if any byte of its inclusive range (start not above end) lies in the protected region. Otherwise it is granted.
- R9: A chip erase is denied whenever the protect code selects a non-empty region.
- R10: A granted modifying request holds busy high for exactly BUSY_CYCLES cycles, starting the cycle after the grant. When busy ends, the latch clears unless a write enable arrives on that same edge.
- R11: A modifying request that is denied while not busy clears the latch and does not set busy.
- R12: While busy, every modifying request is denied and changes nothing. Status read, write enable and write disable stay granted.
- R13: Each request gets a one-cycle response in the next cycle. Code 7 is denied and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R3) |
| req_lo | input | ADDR_W | First byte address of program/erase range |
| req_hi | input | ADDR_W | Last byte address of program/erase range |
| req_wdata | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Status register value |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_grant | output | 1 | Request granted (valid with resp_valid) |
| busy | output | 1 | Operation in progress |

## Verification
The bench builds the block with the default 19-bit address, which is the 512-kB array the protect table is written for, and sets BUSY_CYCLES to 5. The short busy window lets random traffic often land requests inside a busy period. It also lets requests arrive on the exact edge where busy ends, so the race between a write enable and the completion clear is exercised. Every protect code is visited with accesses one byte inside and one byte outside each region edge.

// File: rtl/sflash_prot_pkg.sv
package sflash_prot_pkg;

  typedef enum logic [2:0] {
    OP_RDSR  = 3'd0,
    OP_WREN  = 3'd1,
    OP_WRDI  = 3'd2,
    OP_STWR  = 3'd3,
    OP_PROG  = 3'd4,
    OP_ERASE = 3'd5,
    OP_CHIP  = 3'd6,
    OP_RSVD  = 3'd7
  } sf_op_e;

  typedef struct packed {
    logic       lock;
    logic       rsv;
    logic [3:0] code;
    logic       wel;
    logic       wip;
  } sf_status_t;

  function automatic logic is_modify(sf_op_e op);
    return (op == OP_STWR) || (op == OP_PROG) || (op == OP_ERASE) || (op == OP_CHIP);
  endfunction

  function automatic logic is_always_ok(sf_op_e op);
    return (op == OP_RDSR) || (op == OP_WREN) || (op == OP_WRDI);
  endfunction

endpackage

// File: rtl/sprot_range_dec.sv
// Maps the four-bit protect code to an inclusive protected address window.
module sprot_range_dec #(
  parameter int ADDR_W = 19
) (
  input  logic [3:0]        code,
  output logic              en,
  output logic [ADDR_W-1:0] lo,
  output logic [ADDR_W-1:0] hi
);
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(MEM_BYTES - 1);
  localparam logic [ADDR_W-1:0] A_ZERO = '0;
  // top-aligned windows: eighth, quarter, half
  localparam logic [ADDR_W-1:0] T_EIGHTH  = ADDR_W'(MEM_BYTES - (MEM_BYTES >> 3));
  localparam logic [ADDR_W-1:0] T_QUARTER = ADDR_W'(MEM_BYTES - (MEM_BYTES >> 2));
  localparam logic [ADDR_W-1:0] T_HALF    = ADDR_W'(MEM_BYTES - (MEM_BYTES >> 1));
  // bottom-aligned windows leaving a top slice unprotected
  localparam logic [ADDR_W-1:0] B_GAP7 = ADDR_W'(MEM_BYTES - (MEM_BYTES >> 7) - 1);
  localparam logic [ADDR_W-1:0] B_GAP6 = ADDR_W'(MEM_BYTES - (MEM_BYTES >> 6) - 1);
  localparam logic [ADDR_W-1:0] B_GAP5 = ADDR_W'(MEM_BYTES - (MEM_BYTES >> 5) - 1);
  localparam logic [ADDR_W-1:0] B_GAP4 = ADDR_W'(MEM_BYTES - (MEM_BYTES >> 4) - 1);
  localparam logic [ADDR_W-1:0] B_GAP2 = ADDR_W'(MEM_BYTES - (MEM_BYTES >> 2) - 1);
  localparam logic [ADDR_W-1:0] B_GAP1 = ADDR_W'(MEM_BYTES - (MEM_BYTES >> 1) - 1);

  always_comb begin
    en = 1'b1;
    lo = A_ZERO;
    hi = A_TOP;
    unique case (code)
      4'b0000, 4'b1000: begin en = 1'b0; hi = A_ZERO; end
      4'b0001: lo = T_EIGHTH;
      4'b0010: lo = T_QUARTER;
      4'b0011: lo = T_HALF;
      4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1111: ;
      4'b1001: hi = B_GAP7;
      4'b1010: hi = B_GAP6;
      4'b1011: hi = B_GAP5;
      4'b1100: hi = B_GAP4;
      4'b1101: hi = B_GAP2;
      4'b1110: hi = B_GAP1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sprot_overlap.sv
// Flags any shared byte between a request range and the protected window.
module sprot_overlap #(
  parameter int ADDR_W = 19
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  input  logic [ADDR_W-1:0] req_lo,
  input  logic [ADDR_W-1:0] req_hi,
  output logic              hit
);
  always_comb begin
    hit = en && (req_lo <= win_hi) && (req_hi >= win_lo);
  end
endmodule

// File: rtl/sprot_busy_timer.sv
// Counts the modelled operation time after a start pulse.
module sprot_busy_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic running,
  output logic done
);
  localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= LOAD;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sflash_prot_top.sv
module sflash_prot_top
  import sflash_prot_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_lo,
  input  logic [ADDR_W-1:0] req_hi,
  input  logic [7:0]        req_wdata,
  input  logic              wp_n,
  output logic [7:0]        status,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic              busy
);
  sf_op_e           op;
  logic             wel_q;
  logic             lock_q;
  logic [3:0]       code_q;
  logic             wip;
  logic             tmr_done;
  logic             win_en;
  logic [ADDR_W-1:0] win_lo, win_hi;
  logic             hit;
  logic             hw_lock;
  logic             permit;
  logic             start;
  logic             grant_c;
  logic             unused_wdata_bits;
  sf_status_t       st;

  assign op = sf_op_e'(req_op);
  assign unused_wdata_bits = ^{req_wdata[6], req_wdata[1:0]};

  sprot_range_dec #(.ADDR_W(ADDR_W)) u_dec (
    .code (code_q),
    .en   (win_en),
    .lo   (win_lo),
    .hi   (win_hi)
  );

  sprot_overlap #(.ADDR_W(ADDR_W)) u_ovl (
    .en     (win_en),
    .win_lo (win_lo),
    .win_hi (win_hi),
    .req_lo (req_lo),
    .req_hi (req_hi),
    .hit    (hit)
  );

  sprot_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .running (wip),
    .done    (tmr_done)
  );

  assign hw_lock = lock_q && !wp_n;

  always_comb begin
    unique case (op)
      OP_STWR:           permit = !hw_lock;
      OP_PROG, OP_ERASE: permit = !hit;
      OP_CHIP:           permit = !win_en;
      default:           permit = 1'b0;
    endcase
    start   = req_valid && is_modify(op) && !wip && wel_q && permit;
    grant_c = req_valid && (is_always_ok(op) || start);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q      <= 1'b0;
      lock_q     <= 1'b0;
      code_q     <= '0;
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_grant <= grant_c;
      if (tmr_done) wel_q <= 1'b0;
      if (req_valid) begin
        if (op == OP_WREN) begin
          wel_q <= 1'b1;
        end else if (op == OP_WRDI) begin
          wel_q <= 1'b0;
        end else if (is_modify(op) && !wip) begin
          if (start) begin
            if (op == OP_STWR) begin
              code_q <= req_wdata[5:2];
              lock_q <= req_wdata[7];
            end
          end else begin
            wel_q <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    st.lock = lock_q;
    st.rsv  = 1'b0;
    st.code = code_q;
    st.wel  = wel_q;
    st.wip  = wip;
  end

  assign status = st;
  assign busy   = wip;

endmodule

// File: rtl/sflash_prot_chk.sv
module sflash_prot_chk
  import sflash_prot_pkg::*;
#(
  parameter int BUSY_CYCLES = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       wp_n,
  input logic [7:0] status,
  input logic       resp_valid,
  input logic       resp_grant
);
  int wip_run;

  always_ff @(posedge clk) begin
    if (rst)            wip_run <= 0;
    else if (status[0]) wip_run <= wip_run + 1;
    else                wip_run <= 0;
  end

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
    status[6] == 1'b0);

  assert_resp_follows_R13: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  assert_resp_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);

  assert_wel_needed_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid && is_modify(sf_op_e'(req_op)) && !status[1] |=> !resp_grant);

  assert_hw_lock_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid && (sf_op_e'(req_op) == OP_STWR) && status[7] && !wp_n
    |=> !resp_grant && $stable(status[7:2]));

  assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (rst)
    req_valid && is_modify(sf_op_e'(req_op)) && status[0] |=> !resp_grant);

  assert_grant_sets_wip_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_grant && $past(is_modify(sf_op_e'(req_op))) |-> status[0]);

  assert_wip_len_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(status[0]) |-> wip_run == BUSY_CYCLES);

  assert_done_clears_wel_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(status[0]) && !$past(req_valid && (sf_op_e'(req_op) == OP_WREN)) |-> !status[1]);

  assert_deny_clears_wel_R11: assert property (@(posedge clk) disable iff (rst)
    resp_valid && !resp_grant && $past(is_modify(sf_op_e'(req_op)) && !status[0])
    |-> !status[1] && !status[0]);

endmodule

bind sflash_prot_top sflash_prot_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .wp_n       (wp_n),
  .status     (status),
  .resp_valid (resp_valid),
  .resp_grant (resp_grant)
);

// File: tb/sim_sflash_prot_top.sv
`timescale 1ns/1ps
module sim_sflash_prot_top;
  localparam int AW  = 19;
  localparam int BC  = 5;
  localparam int TOP = 32'h7FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = 3'd0;
  logic [AW-1:0] req_lo = '0;
  logic [AW-1:0] req_hi = '0;
  logic [7:0]    req_wdata = 8'h00;
  logic          wp_n = 1'b1;
  wire  [7:0]    status;
  wire           resp_valid, resp_grant, busy;

  always #2 clk = ~clk;

  sflash_prot_top #(.ADDR_W(AW), .BUSY_CYCLES(BC)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_lo(req_lo), .req_hi(req_hi), .req_wdata(req_wdata), .wp_n(wp_n),
    .status(status), .resp_valid(resp_valid), .resp_grant(resp_grant), .busy(busy)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // reference state
  bit m_wip, m_wel, m_lock;
  bit [3:0] m_code;
  int m_cnt;
  bit e_rv, e_g;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Protected windows for a 512-kB array, straight from R6/R7.
  function automatic void prot_range(input bit [3:0] c, output bit en, output int lo, output int hi);
    en = 1; lo = 0; hi = TOP;
    case (c)
      4'h0, 4'h8: begin en = 0; hi = 0; end
      4'h1: lo = 32'h70000;
      4'h2: lo = 32'h60000;
      4'h3: lo = 32'h40000;
      4'h9: hi = 32'h7EFFF;
      4'hA: hi = 32'h7DFFF;
      4'hB: hi = 32'h7BFFF;
      4'hC: hi = 32'h77FFF;
      4'hD: hi = 32'h5FFFF;
      4'hE: hi = 32'h3FFFF;
      default: ;
    endcase
  endfunction

  function automatic bit [7:0] m_status();
    return {m_lock, 1'b0, m_code, m_wel, m_wip};
  endfunction

  task automatic model_cycle(bit v, int op, int lo, int hi, bit [7:0] d, bit wpn);
    bit ow, oe, ol, en, ok;
    bit [3:0] oc;
    int plo, phi;
    ow = m_wip; oe = m_wel; ol = m_lock; oc = m_code;
    if (ow) begin
      if (m_cnt == 0) begin m_wip = 0; m_wel = 0; end
      else m_cnt--;
    end
    e_rv = v; e_g = 0;
    if (v) begin
      case (op)
        0: e_g = 1;
        1: begin e_g = 1; m_wel = 1; end
        2: begin e_g = 1; m_wel = 0; end
        3, 4, 5, 6: begin
          if (!ow) begin
            prot_range(oc, en, plo, phi);
            if (op == 3)      ok = !(ol && !wpn);
            else if (op == 6) ok = !en;
            else              ok = !(en && lo <= phi && hi >= plo);
            if (oe && ok) begin
              e_g = 1; m_wip = 1; m_cnt = BC - 1;
              if (op == 3) begin m_code = d[5:2]; m_lock = d[7]; end
            end else begin
              m_wel = 0;
            end
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic tick(bit v, int op, int lo, int hi, bit [7:0] d, bit wpn, string tag);
    req_valid = v; req_op = 3'(op); req_lo = AW'(lo); req_hi = AW'(hi);
    req_wdata = d; wp_n = wpn;
    @(posedge clk);
    model_cycle(v, op, lo, hi, d, wpn);
    @(negedge clk);
    chk(resp_valid === e_rv, tag, "resp_valid", int'(resp_valid), int'(e_rv));
    if (e_rv) chk(resp_grant === e_g, tag, "resp_grant", int'(resp_grant), int'(e_g));
    chk(status === m_status(), tag, "status", int'(status), int'(m_status()));
    chk(busy === m_wip, tag, "busy", int'(busy), int'(m_wip));
  endtask

  task automatic idle(string tag);
    tick(0, 0, 0, 0, 8'h00, 1, tag);
  endtask

  task automatic wait_idle(string tag);
    while (m_wip) idle(tag);
    idle(tag);
  endtask

  task automatic set_status(bit [7:0] d, string tag);
    wait_idle(tag);
    tick(1, 1, 0, 0, 8'h00, 1, tag);
    tick(1, 3, 0, 0, d, 1, tag);
    wait_idle(tag);
  endtask

  task automatic wr_then(int op, int lo, int hi, string tag);
    wait_idle(tag);
    tick(1, 1, 0, 0, 8'h00, 1, "R3");
    tick(1, op, lo, hi, 8'h00, 1, tag);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired before completion (all requirements)");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit en;
    int plo, phi;
    string tg;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 0;
    m_wip = 0; m_wel = 0; m_lock = 0; m_code = 0; m_cnt = 0;
    // R1 reset state
    idle("R1");

    // R4 modify without latch
    tick(1, 4, 0, 0, 8'h00, 1, "R4");
    tick(1, 3, 0, 0, 8'hFF, 1, "R4");
    // R13 unsupported code
    tick(1, 1, 0, 0, 8'h00, 1, "R3");
    tick(1, 7, 0, 0, 8'hFF, 1, "R13");
    tick(1, 2, 0, 0, 8'h00, 1, "R3");
    tick(1, 0, 0, 0, 8'h00, 1, "R3");

    // R2 reserved bit and ignored data bits
    set_status(8'hFF, "R2");
    set_status(8'h00, "R2");

    // R5 hardware lock
    set_status(8'h80, "R5");
    tick(1, 1, 0, 0, 8'h00, 0, "R3");
    tick(1, 3, 0, 0, 8'h3C, 0, "R5");
    idle("R5");
    tick(1, 1, 0, 0, 8'h00, 1, "R3");
    tick(1, 3, 0, 0, 8'h00, 1, "R5");
    wait_idle("R5");

    // R12 busy blocking, R10 completion with WREN on the last edge
    wr_then(4, 100, 200, "R10");
    tick(1, 3, 0, 0, 8'h3C, 1, "R12");
    tick(1, 0, 0, 0, 8'h00, 1, "R12");
    tick(1, 2, 0, 0, 8'h00, 1, "R12");
    tick(1, 1, 0, 0, 8'h00, 1, "R12");
    tick(1, 1, 0, 0, 8'h00, 1, "R10");
    idle("R10");
    wr_then(5, 0, 0, "R10");
    repeat (BC - 1) idle("R10");
    tick(1, 1, 0, 0, 8'h00, 1, "R10");
    idle("R10");
    // R11 denied op clears latch
    tick(1, 1, 0, 0, 8'h00, 1, "R3");
    set_status(8'h04, "R6");
    wr_then(4, TOP, TOP, "R11");

    // R6/R7/R8/R9 every protect code with edge probes
    for (int c = 0; c < 16; c++) begin
      tg = (c < 8) ? "R6" : "R7";
      set_status(8'(c << 2), tg);
      prot_range(4'(c), en, plo, phi);
      wr_then(6, 0, TOP, "R9");
      if (en) begin
        wr_then(4, plo, plo, tg);
        wr_then(4, phi, phi, tg);
        if (phi < TOP) begin
          wr_then(4, phi + 1, phi + 1, tg);
          wr_then(5, phi, phi + 1, "R8");
          wr_then(5, phi + 1, TOP, "R8");
        end
        if (plo > 0) begin
          wr_then(4, plo - 1, plo - 1, tg);
          wr_then(5, plo - 1, plo, "R8");
          wr_then(5, 0, plo - 1, "R8");
        end
      end else begin
        wr_then(5, 0, TOP, "R8");
      end
    end
    set_status(8'h00, "R6");

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int r, op, lo, hi, len;
      bit [7:0] d;
      bit wpn;
      r = $urandom % 100;
      if (r < 25)      op = 1;
      else if (r < 30) op = 2;
      else if (r < 35) op = 0;
      else if (r < 45) op = 3;
      else if (r < 70) op = 4;
      else if (r < 85) op = 5;
      else if (r < 88) op = 6;
      else if (r < 90) op = 7;
      else             op = -1;
      lo  = $urandom % (TOP + 1);
      len = (($urandom % 2) == 0) ? ($urandom % 16) : ($urandom % 65536);
      hi  = (lo + len > TOP) ? TOP : lo + len;
      d   = 8'($urandom);
      if (($urandom % 4) != 0) d[7] = 1'b0;
      wpn = (($urandom % 5) != 0);
      if (op < 0) idle("R13");
      else tick(1, op, lo, hi, d, wpn, (op >= 3 && op <= 5) ? "R8" : "R12");
    end
    wait_idle("R10");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule